// File: doc/BRIEF.md
# Clock-Enable Configuration Serial Slave

This block is a small two-wire serial slave that loads a bank of clock-enable control bytes. The serial clock and data lines are sampled by the system clock through a short synchronizer. Edges found there drive a state machine that follows one fixed write format. That format is the device address with the write bit, a command byte that must be zero, a byte count, and then data bytes. The data bytes fill the control registers one after another, starting at register 0. Because writes are always sequential, a host that wants to change register N must also resend registers 0 to N-1.

Every register comes out of reset holding a default value, so the clocks it controls run with no bus traffic at all. A host can read the bank back for verification by addressing the device with the read bit set. The slave then returns register 0, register 1 and so on, for as long as the host keeps acknowledging. The data line is open-drain: the block never drives it high and only asserts a pull-low output.

The state machine has seven states. ST_IDLE waits for a start condition. ST_ADDR receives the address byte. ST_CMD receives the command byte. ST_COUNT receives the byte count. ST_DATA receives data bytes. ST_READ returns register contents. ST_IGNORE stays silent until the next start condition.

Its transitions are:
- start: any state to ST_ADDR.
- stop: any state to ST_IDLE.
- addr_wr: ST_ADDR to ST_CMD.
- addr_rd: ST_ADDR to ST_READ.
- addr_miss: ST_ADDR to ST_IGNORE.
- cmd_ok: ST_CMD to ST_COUNT.
- cmd_bad: ST_CMD to ST_IGNORE.
- count_taken: ST_COUNT to ST_DATA.
- data_reject: ST_DATA to ST_IGNORE.
- host_nack: ST_READ to ST_IGNORE.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset every control byte holds 0xFF, byte i sits at cfg_regs_o[8i+7:8i], and sda_drive_low_o is 0.
- R2: SDA falling while SCL is high is a start, and SDA rising while SCL is high is a stop. A start seen during any transaction, including partway through a byte, restarts address reception.
- R3: Bytes arrive MSB first. The address byte 0xD2 (address 0x69, write), then a command byte 0x00, then any count byte are each acknowledged, meaning SDA is held low during the ninth clock.
- R4: The slave only begins pulling SDA low while SCL is low.
- R5: If the address byte is neither 0xD2 nor 0xD3, or the command byte is not 0x00, that byte is not acknowledged (SDA stays high in the ninth clock). Every further byte up to the next start is also not acknowledged and leaves the registers unchanged.
- R6: The data bytes after the count are written to registers 0, 1, 2 and onward, in order, and each one is acknowledged.
- R7: A data byte beyond the byte count, or beyond the last register, is not acknowledged and is discarded, and so are all bytes after it until the next start.
- R8: A stop, or a start, in the middle of a transaction keeps every byte already acknowledged. A byte that was only partly received is dropped.
- R9: After address byte 0xD3 (acknowledged), the slave sends register 0, then 1 and onward, MSB first. Past the last register it sends 0xFF. When the host does not acknowledge a byte, the slave releases SDA and stays silent until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired line) |
| sda_drive_low_o | output | 1 | When 1, the open-drain pad pulls SDA low |
| cfg_regs_o | output | NREG*8 | Control register bank, byte i at bits [8i+7:8i] |

## Verification
Two functions can fall in the same cycle. One is start detection. The other is the per-byte bookkeeping: bit counting, the acknowledge decision and the register commit. The bench provokes this by writing one data byte, clocking in only four bits of the next, and then issuing a repeated start. The start must cancel the partial byte without a commit, and a read-back must show the committed byte in register 0 and the old value in register 1. A stop placed right after an acknowledged data byte is checked the same way.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_COUNT,
        ST_DATA,
        ST_READ,
        ST_IGNORE
    } slv_state_t;

    localparam logic [6:0] DEV_ADDR = 7'h69;
    localparam logic [7:0] CMD_CODE = 8'h00;
    localparam logic [7:0] PAST_END = 8'hFF;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES:0] scl_sh;
    logic [STAGES:0] sda_sh;
    logic            scl_old;
    logic            sda_old;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[STAGES-1:0], scl_i};
            sda_sh <= {sda_sh[STAGES-1:0], sda_i};
        end
    end

    assign scl_lvl   = scl_sh[STAGES-1];
    assign sda_lvl   = sda_sh[STAGES-1];
    assign scl_old   = scl_sh[STAGES];
    assign sda_old   = sda_sh[STAGES];
    assign scl_rise  = scl_lvl & ~scl_old;
    assign scl_fall  = ~scl_lvl & scl_old;
    assign start_det = scl_lvl & scl_old & sda_old & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_old & ~sda_old & sda_lvl;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
    parameter int         NREG  = 6,
    parameter int         IDX_W = 3,
    parameter logic [7:0] DEF   = 8'hFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [7:0]          wr_data,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [NREG*8-1:0]   regs_o,
    output logic [7:0]          rd_data
);
    for (genvar g = 0; g < NREG; g++) begin : g_byte
        logic [7:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                val_q <= DEF;
            else if (wr_en && wr_idx == IDX_W'(g))
                val_q <= wr_data;
        end
        assign regs_o[g*8 +: 8] = val_q;
    end

    always_comb begin
        rd_data = cfgi2c_pkg::PAST_END;
        for (int i = 0; i < NREG; i++)
            if (rd_idx == IDX_W'(i))
                rd_data = regs_o[i*8 +: 8];
    end
endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
    import cfgi2c_pkg::*;
#(
    parameter int         NREG    = 6,
    parameter logic [7:0] DEF_VAL = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_drive_low_o,
    output logic [NREG*8-1:0] cfg_regs_o
);
    localparam int IDX_W = $clog2(NREG + 1);

    logic scl_s, scl_rise, scl_fall, sda_s, start_det, stop_det;

    slv_state_t       state_q, state_d;
    logic [3:0]       bit_cnt_q;
    logic             ack_phase_q;
    logic             mst_nack_q;
    logic [7:0]       shreg_q;
    logic [7:0]       left_q;
    logic [IDX_W-1:0] wr_idx_q, rd_idx_q;
    logic [7:0]       tx_byte;
    logic             drive_q;

    logic active, byte_done, ack_end, accept, wr_en;

    i2c_line_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfg_reg_bank #(.NREG(NREG), .IDX_W(IDX_W), .DEF(DEF_VAL)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx_q),
        .wr_data (shreg_q),
        .rd_idx  (rd_idx_q),
        .regs_o  (cfg_regs_o),
        .rd_data (tx_byte)
    );

    // byte-level decisions and next state
    always_comb begin
        active    = (state_q != ST_IDLE) && (state_q != ST_IGNORE);
        byte_done = scl_fall && !ack_phase_q && (bit_cnt_q == 4'd8) && active;
        ack_end   = scl_fall && ack_phase_q;
        unique case (state_q)
            ST_ADDR:  accept = (shreg_q[7:1] == DEV_ADDR);
            ST_CMD:   accept = (shreg_q == CMD_CODE);
            ST_COUNT: accept = 1'b1;
            ST_DATA:  accept = (left_q != 8'd0) && (wr_idx_q < IDX_W'(NREG));
            default:  accept = 1'b0;
        endcase
        wr_en   = byte_done && (state_q == ST_DATA) && accept;
        state_d = state_q;
        if (start_det)
            state_d = ST_ADDR;
        else if (stop_det)
            state_d = ST_IDLE;
        else if (byte_done) begin
            unique case (state_q)
                ST_ADDR:  state_d = !accept ? ST_IGNORE : (shreg_q[0] ? ST_READ : ST_CMD);
                ST_CMD:   state_d = accept ? ST_COUNT : ST_IGNORE;
                ST_COUNT: state_d = ST_DATA;
                ST_DATA:  state_d = accept ? ST_DATA : ST_IGNORE;
                default:  state_d = state_q;
            endcase
        end else if (ack_end && state_q == ST_READ && mst_nack_q)
            state_d = ST_IGNORE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // bit and byte bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q   <= '0;
            ack_phase_q <= 1'b0;
            mst_nack_q  <= 1'b0;
            shreg_q     <= '0;
            left_q      <= '0;
            wr_idx_q    <= '0;
            rd_idx_q    <= '0;
        end else if (start_det || stop_det) begin
            bit_cnt_q   <= '0;
            ack_phase_q <= 1'b0;
            mst_nack_q  <= 1'b0;
        end else begin
            if (scl_rise && !ack_phase_q) begin
                shreg_q <= {shreg_q[6:0], sda_s};
                if (bit_cnt_q != 4'd8) bit_cnt_q <= bit_cnt_q + 4'd1;
            end
            if (scl_rise && ack_phase_q)
                mst_nack_q <= sda_s;
            if (ack_end) begin
                ack_phase_q <= 1'b0;
                bit_cnt_q   <= '0;
            end
            if (byte_done) begin
                ack_phase_q <= 1'b1;
                bit_cnt_q   <= '0;
                if (state_q == ST_ADDR && accept) rd_idx_q <= '0;
                if (state_q == ST_COUNT) begin
                    left_q   <= shreg_q;
                    wr_idx_q <= '0;
                end
                if (state_q == ST_READ && rd_idx_q != IDX_W'(NREG))
                    rd_idx_q <= rd_idx_q + IDX_W'(1);
            end
            if (wr_en) begin
                wr_idx_q <= wr_idx_q + IDX_W'(1);
                left_q   <= left_q - 8'd1;
            end
        end
    end

    // pad output: changes only on SCL falling edges, or is released at start and stop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            drive_q <= 1'b0;
        else if (start_det || stop_det)
            drive_q <= 1'b0;
        else if (byte_done)
            drive_q <= accept;
        else if (ack_end)
            drive_q <= (state_q == ST_READ && !mst_nack_q) ? ~tx_byte[7] : 1'b0;
        else if (scl_fall && state_q == ST_READ && !ack_phase_q)
            drive_q <= ~tx_byte[3'(3'd7 - bit_cnt_q[2:0])];
    end

    assign sda_drive_low_o = drive_q;
endmodule

// File: rtl/cfg_i2c_checker.sv
module cfg_i2c_checker
    import cfgi2c_pkg::*;
#(
    parameter int NREG = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              start_det,
    input logic              stop_det,
    input slv_state_t        state_q,
    input logic              ack_phase_q,
    input logic              sda_drive_low_o,
    input logic [NREG*8-1:0] cfg_regs_o
);
    AST_PULL_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low_o) |-> !$past(scl_s)); // R4

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> state_q == ST_ADDR); // R2

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> state_q == ST_IDLE); // R8

    AST_REGS_ONLY_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_regs_o) |-> $past(state_q) == ST_DATA); // R6

    AST_WRITE_PULL_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low_o && state_q != ST_READ) |-> ack_phase_q); // R3

    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IGNORE |-> !sda_drive_low_o); // R5
endmodule

bind clkcfg_i2c_slave cfg_i2c_checker #(.NREG(NREG)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_s           (scl_s),
    .start_det       (start_det),
    .stop_det        (stop_det),
    .state_q         (state_q),
    .ack_phase_q     (ack_phase_q),
    .sda_drive_low_o (sda_drive_low_o),
    .cfg_regs_o      (cfg_regs_o)
);

// File: tb/sim_clkcfg_i2c_slave.sv
module sim_clkcfg_i2c_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q    = 8;
    localparam int NREG = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic drv;
    logic [NREG*8-1:0] regs;
    wire  sda_line = m_sda & ~drv;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        string      req;
        logic [7:0] val;
    } exp_t;
    exp_t       exp_q[$];
    exp_t       cur;
    logic [7:0] obs_val;
    event       obs_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkcfg_i2c_slave #(.NREG(NREG)) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (m_scl),
        .sda_i           (sda_line),
        .sda_drive_low_o (drv),
        .cfg_regs_o      (regs)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops expected items and compares with observed results
    initial begin
        forever begin
            @(obs_ev);
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL scoreboard: actual %h expected none", obs_val);
            end else begin
                cur = exp_q.pop_front();
                check(cur.req, obs_val, cur.val);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic observe(logic [7:0] v);
        obs_val = v;
        ->obs_ev;
        tick(1);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(2*Q);
    endtask

    task automatic send_bit(logic b);
        m_sda = b;    tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
    endtask

    // exp_nack: 0 = acknowledged (SDA low in ninth clock), 1 = not acknowledged
    task automatic write_byte(logic [7:0] b, string req, logic exp_nack);
        exp_q.push_back('{req, {7'd0, exp_nack}});
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        observe({7'd0, sda_line});
        tick(Q - 1);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic read_byte(logic [7:0] exp, string req, logic host_ack);
        logic [7:0] v;
        v = '0;
        exp_q.push_back('{req, exp});
        for (int i = 0; i < 8; i++) begin
            m_sda = 1'b1; tick(Q);
            m_scl = 1'b1; tick(Q);
            v = {v[6:0], sda_line};
            tick(Q);
            m_scl = 1'b0; tick(Q);
        end
        observe(v);
        send_bit(!host_ack);
        m_sda = 1'b1;
    endtask

    task automatic reg_chk(int idx, logic [7:0] exp, string req);
        exp_q.push_back('{req, exp});
        observe(regs[idx*8 +: 8]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(4);

        // R1 reset state
        for (int i = 0; i < NREG; i++) reg_chk(i, 8'hFF, "R1 default byte");
        check("R1 no pull after reset", {7'd0, drv}, 8'h00);

        // R3 R6 basic write of three bytes
        i2c_start();
        write_byte(8'hD2, "R3 address ack", 1'b0);
        write_byte(8'h00, "R3 command ack", 1'b0);
        write_byte(8'h03, "R3 count ack", 1'b0);
        write_byte(8'h11, "R6 data0 ack", 1'b0);
        write_byte(8'h22, "R6 data1 ack", 1'b0);
        write_byte(8'h33, "R6 data2 ack", 1'b0);
        i2c_stop();
        reg_chk(0, 8'h11, "R6 reg0");
        reg_chk(1, 8'h22, "R6 reg1");
        reg_chk(2, 8'h33, "R6 reg2");
        reg_chk(3, 8'hFF, "R6 reg3 untouched");

        // R5 wrong address
        i2c_start();
        write_byte(8'hA0, "R5 bad address nack", 1'b1);
        write_byte(8'h00, "R5 ignored byte nack", 1'b1);
        write_byte(8'h01, "R5 ignored byte nack", 1'b1);
        write_byte(8'h99, "R5 ignored data nack", 1'b1);
        i2c_stop();
        reg_chk(0, 8'h11, "R5 reg0 kept after bad address");

        // R5 wrong command code
        i2c_start();
        write_byte(8'hD2, "R3 address ack", 1'b0);
        write_byte(8'h05, "R5 bad command nack", 1'b1);
        write_byte(8'h01, "R5 ignored byte nack", 1'b1);
        write_byte(8'h99, "R5 ignored data nack", 1'b1);
        i2c_stop();
        reg_chk(0, 8'h11, "R5 reg0 kept after bad command");

        // R7 beyond byte count
        i2c_start();
        write_byte(8'hD2, "R3 address ack", 1'b0);
        write_byte(8'h00, "R3 command ack", 1'b0);
        write_byte(8'h01, "R3 count ack", 1'b0);
        write_byte(8'hAA, "R6 data0 ack", 1'b0);
        write_byte(8'hBB, "R7 over count nack", 1'b1);
        i2c_stop();
        reg_chk(0, 8'hAA, "R7 reg0 written");
        reg_chk(1, 8'h22, "R7 reg1 not overwritten");

        // R7 beyond last register
        i2c_start();
        write_byte(8'hD2, "R3 address ack", 1'b0);
        write_byte(8'h00, "R3 command ack", 1'b0);
        write_byte(8'h08, "R3 count ack", 1'b0);
        for (int i = 0; i < NREG; i++) write_byte(8'h40 + 8'(i), "R6 data ack", 1'b0);
        write_byte(8'h46, "R7 past last register nack", 1'b1);
        i2c_stop();
        reg_chk(NREG-1, 8'h45, "R7 last register kept");

        // R9 read back, including one byte past the end
        i2c_start();
        write_byte(8'hD3, "R9 read address ack", 1'b0);
        for (int i = 0; i < NREG; i++) read_byte(8'h40 + 8'(i), "R9 read byte", 1'b1);
        read_byte(8'hFF, "R9 past end reads FF", 1'b0);
        tick(Q);
        check("R9 released after host nack", {7'd0, drv}, 8'h00);
        i2c_stop();

        // R2 R8 repeated start in the middle of a data byte
        i2c_start();
        write_byte(8'hD2, "R3 address ack", 1'b0);
        write_byte(8'h00, "R3 command ack", 1'b0);
        write_byte(8'h03, "R3 count ack", 1'b0);
        write_byte(8'h50, "R6 data0 ack", 1'b0);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        i2c_start();
        write_byte(8'hD3, "R2 address after repeated start", 1'b0);
        read_byte(8'h50, "R8 committed byte kept", 1'b1);
        read_byte(8'h41, "R8 partial byte dropped", 1'b0);
        i2c_stop();

        // R8 stop right after a data byte
        i2c_start();
        write_byte(8'hD2, "R3 address ack", 1'b0);
        write_byte(8'h00, "R3 command ack", 1'b0);
        write_byte(8'h03, "R3 count ack", 1'b0);
        write_byte(8'h60, "R6 data0 ack", 1'b0);
        i2c_stop();
        reg_chk(0, 8'h60, "R8 reg0 kept after stop");
        reg_chk(1, 8'h41, "R8 reg1 untouched after stop");

        tick(4);
        if (exp_q.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule